// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Base

This block is an 8-bit accumulator attached to one external input line. It runs in one of two modes. In event mode every selected edge on the line adds one to the count. In gated mode the line acts as an enable for a free-running tick. The tick fires once every 64 system clock cycles, and while the line sits at its chosen level, each tick adds one to the count. The time the line spends active is then recorded in units of 64 clocks.

A processor reaches the block through a small register port. It can read and overwrite the count at any moment. It sets the mode, the polarity and the enables in a control register. It clears the status flags by writing ones to them. Two interrupt requests leave the block, each masked by its own enable. One comes from a count wrapping past its maximum. The other comes from an edge on the input line. The line is asynchronous, so two flip-flops synchronise it before any edge is detected.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count (address 0), the control register (address 1) and the flag register (address 2) all read 0, and both interrupt outputs are low.
- R2: In event mode (control bit 1 = 0) with the accumulator on (control bit 0 = 1), each active edge on `pulse_in` adds exactly one to the count. Control bit 2 selects the edge: 1 selects rising, 0 selects falling. The other edge leaves the count unchanged.
- R3: In gated mode (control bit 1 = 1) the count rises by one on every 64th system clock while `pulse_in` is at the active level. Control bit 2 sets that level: 1 means high and 0 means low. Holding the line active for 64·k cycles adds exactly k. The count does not change while the line is inactive.
- R4: The count can be read at address 0 and overwritten at address 0 at any time. When a write and an increment fall in the same cycle, the written value is kept.
- R5: When an increment takes the count from 0xFF to 0x00, the overflow flag (flag bit 0) is set. Loading 0x00 by a write does not set it.
- R6: The edge flag (flag bit 1) is set in event mode by each active edge. In gated mode it is set by the trailing edge of the gate, which is the change from active to inactive level. The leading edge of the gate does not set it.
- R7: Writing 1 to a flag bit at address 2 clears that bit, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R8: `ovf_irq` is high exactly while flag bit 0 and control bit 4 are both 1. `edge_irq` is high exactly while flag bit 1 and control bit 5 are both 1.
- R9: With control bit 0 at 0, input activity neither changes the count nor sets either flag.
- R10: Suppose `pulse_in` changes before rising clock edge E0. Then the resulting increment is visible after the third rising edge, counting E0 as the first, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also drives the divide-by-64 tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 count, 1 control, 2 flags |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| pulse_in | input | 1 | Asynchronous event or gate input |
| ovf_irq | output | 1 | Masked overflow interrupt request |
| edge_irq | output | 1 | Masked input-edge interrupt request |

## Verification
Event counting is driven with pulse trains under both edge polarities. This distinguishes a counter that responds to the selected edge from one that responds to any transition. Gated counting is driven with gate windows that are exact multiples of 64 cycles, at both active levels. An exact count then shows that the tick rate is right and that the level is decoded correctly. A long inactive stretch shows that the tick is being gated. Single-cycle alignments check three things: the increment latency, a write landing on the same cycle as an increment, and a flag clear landing on the same cycle as a flag set. Counts loaded near the wrap point separate overflow by increment from a written zero.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             pulse_in,
  output logic             ovf_irq,
  output logic             edge_irq
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    psc;
  logic             s1, s2, s3;
  logic             on_q, gated_q, pol_q, ovf_ie_q, edge_ie_q;
  logic             ovf_flag, edge_flag;

  wire tick      = (psc == PW'(PRESCALE - 1));
  wire wr_cnt    = wr_en && addr == 2'd0;
  wire wr_ctl    = wr_en && addr == 2'd1;
  wire wr_flg    = wr_en && addr == 2'd2;
  wire act_edge  = (s2 == pol_q) && (s3 != pol_q);
  wire trail     = (s3 == pol_q) && (s2 != pol_q);
  wire gate_on   = (s2 == pol_q);
  wire inc       = on_q && (gated_q ? (tick && gate_on) : act_edge);
  wire ovf_set   = inc && !wr_cnt && cnt == CNT_MAX;
  wire edge_set  = on_q && (gated_q ? trail : act_edge);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) psc <= '0;
    else        psc <= tick ? '0 : psc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {pulse_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= wr_data;
    else if (inc)    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      {edge_ie_q, ovf_ie_q, pol_q, gated_q, on_q} <= '0;
    else if (wr_ctl)
      {edge_ie_q, ovf_ie_q, pol_q, gated_q, on_q} <=
        {wr_data[5], wr_data[4], wr_data[2], wr_data[1], wr_data[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      ovf_flag  <= ovf_set  | (ovf_flag  & ~(wr_flg & wr_data[0]));
      edge_flag <= edge_set | (edge_flag & ~(wr_flg & wr_data[1]));
    end

  always_comb begin
    rd_data = '0;
    case (addr)
      2'd0: rd_data = cnt;
      2'd1: begin
        rd_data[0] = on_q;
        rd_data[1] = gated_q;
        rd_data[2] = pol_q;
        rd_data[4] = ovf_ie_q;
        rd_data[5] = edge_ie_q;
      end
      2'd2: rd_data[1:0] = {edge_flag, ovf_flag};
      default: rd_data = '0;
    endcase
  end

  assign ovf_irq  = ovf_flag  & ovf_ie_q;
  assign edge_irq = edge_flag & edge_ie_q;

  // R4
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wr_data));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(wr_cnt) |-> cnt == $past(cnt) + 1'b1);

  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt) == CNT_MAX && cnt == '0 && !$past(wr_cnt) |-> ovf_flag);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q && !wr_cnt |=> $stable(cnt));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flg && wr_data[1] && !edge_set |=> !edge_flag);

  // R3
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_q && gated_q && !gate_on && !wr_cnt |=> $stable(cnt));
endmodule

// File: tb/test_pulse_accum.sv
module test_pulse_accum;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       pulse_in = 1'b0;
  logic       ovf_irq, edge_irq;
  int checks = 0;
  int fails = 0;

  pulse_accum i_pulse_accum (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pulse_in(pulse_in), .ovf_irq(ovf_irq), .edge_irq(edge_irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic pin(input logic v);
    @(negedge clk); pulse_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 count", d, 0);
    rd(2'd1, d); check("R1 control", d, 0);
    rd(2'd2, d); check("R1 flags", d, 0);
    check("R1 irqs", {ovf_irq, edge_irq}, 0);
  endtask

  task automatic t_event;
    logic [7:0] d;
    wr(2'd1, 8'h25); wr(2'd0, 8'd0); wr(2'd2, 8'h03);
    for (int i = 0; i < 3; i++) begin pin(1'b1); pin(1'b0); end
    rd(2'd0, d); check("R2 rising count", d, 3);
    rd(2'd2, d); check("R6 event edge flag", d[1], 1);
    check("R8 edge_irq", edge_irq, 1);
    wr(2'd2, 8'h00); rd(2'd2, d); check("R7 write zero keeps", d[1], 1);
    wr(2'd2, 8'h02); rd(2'd2, d); check("R7 write one clears", d[1], 0);
    wr(2'd1, 8'h01); wr(2'd0, 8'd0);
    pin(1'b1); rd(2'd0, d); check("R2 rising ignored when falling", d, 0);
    pin(1'b0); rd(2'd0, d); check("R2 falling counts", d, 1);
  endtask

  task automatic t_latency;
    logic [7:0] d;
    wr(2'd1, 8'h05); wr(2'd0, 8'd10);
    @(negedge clk); addr = 2'd0; pulse_in = 1'b1;
    @(negedge clk); check("R10 after E0", rd_data, 10);
    @(negedge clk); check("R10 after E1", rd_data, 10);
    @(negedge clk); check("R10 after E2", rd_data, 11);
    pin(1'b0);
    rd(2'd0, d); check("R10 settled", d, 11);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(2'd1, 8'h05); wr(2'd2, 8'h03);
    @(negedge clk); addr = 2'd0; pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_data = 8'h55; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd0, d); check("R4 write wins", d, 8'h55);
    pin(1'b0);
    wr(2'd2, 8'h03);
    @(negedge clk); pulse_in = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 2'd2; wr_data = 8'h02; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, d); check("R7 set wins over clear", d[1], 1);
    pin(1'b0);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    wr(2'd1, 8'h15); wr(2'd2, 8'h03); wr(2'd0, 8'hFE);
    pin(1'b1); pin(1'b0);
    rd(2'd2, d); check("R5 no flag at FF", d[0], 0);
    pin(1'b1); pin(1'b0);
    rd(2'd0, d); check("R5 wraps to zero", d, 0);
    rd(2'd2, d); check("R5 overflow flag", d[0], 1);
    check("R8 ovf_irq", ovf_irq, 1);
    wr(2'd2, 8'h01); check("R8 ovf_irq drops", ovf_irq, 0);
    wr(2'd0, 8'hFF); wr(2'd0, 8'h00);
    rd(2'd2, d); check("R5 written zero no flag", d[0], 0);
  endtask

  task automatic t_gated;
    logic [7:0] d;
    wr(2'd1, 8'h07); wr(2'd0, 8'd0); wr(2'd2, 8'h03);
    repeat (200) @(negedge clk);
    rd(2'd0, d); check("R3 inactive gate holds", d, 0);
    @(negedge clk); pulse_in = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd2, d); check("R6 leading edge no flag", d[1], 0);
    repeat (183) @(negedge clk);
    pulse_in = 1'b0;
    repeat (8) @(negedge clk);
    rd(2'd0, d); check("R3 high gate 3 ticks", d, 3);
    rd(2'd2, d); check("R6 trailing edge flag", d[1], 1);
    pin(1'b1);
    wr(2'd1, 8'h03); wr(2'd0, 8'd0);
    @(negedge clk); pulse_in = 1'b0;
    repeat (128) @(negedge clk);
    pulse_in = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd0, d); check("R3 low gate 2 ticks", d, 2);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    wr(2'd1, 8'h34); wr(2'd0, 8'd7); wr(2'd2, 8'h03);
    pin(1'b0); pin(1'b1); pin(1'b0); pin(1'b1);
    rd(2'd0, d); check("R9 count held", d, 7);
    rd(2'd2, d); check("R9 no flags", d, 0);
    pin(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_event();
    t_latency();
    t_collide();
    t_overflow();
    t_gated();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule